// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a free-running oscillator clock into a periodic interrupt. A 7-bit rate value and a mode bit, loaded through a single write strobe, set the period. The top three bits of the rate value pick a prescaler and the bottom four bits pick a multiplier from 1 to 16. The mode bit chooses between two prescaler sets. Binary mode offers powers of two from 2^10 to 2^16, plus one code that switches the divider off. Decimal mode offers eight round values from 1,000 to 200,000 and has no off code.

A prescale counter feeds a multiplier counter. When both counters reach their terminal counts together, the block sets a sticky flag. Software clears the flag by writing a one to it. The interrupt output is the flag gated by an enable input. Any write of the rate value or the mode bit restarts both counters, so the new period is always measured from the write.

Top module: `periodic_tick_divider`

## Requirements
- R1: After synchronous reset, the rate value is 0 and binary mode is selected, so the divider is off. `flag` and `irq` are 0 and stay 0 while no new rate is written.
- R2: In binary mode (`wr_dec`=0), a rate with upper bits u = `wr_rate[6:4]` from 1 to 7 and lower bits m = `wr_rate[3:0]` sets `flag` exactly 2^(9+u)·(m+1) clock edges after the write edge.
- R3: In decimal mode (`wr_dec`=1), upper codes 0 to 7 select prescalers of 1000, 2000, 5000, 10000, 20000, 50000, 100000 and 200000. `flag` sets exactly prescaler·(m+1) edges after the write edge, and upper code 0 is not an off code.
- R4: In binary mode with `wr_rate[6:4]`=000, the divider is off for every value of `wr_rate[3:0]`. Both counters are held at zero and `flag` is never set.
- R5: A write with `wr_en`=1 restarts both counters from zero, so a write made part way through a period pushes the next flag to a full period after that write.
- R6: `flag` is sticky. It is cleared only on an edge where `clr_wr`=1 and `clr_bit`=1. A clear write with `clr_bit`=0 leaves it set.
- R7: `irq` equals `flag` while `irq_en`=1 and is 0 while `irq_en`=0.
- R8: The divider runs freely. Without a new write, successive flag events come every period, so after a clear the flag sets again at twice the period from the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the rate value and mode bit |
| wr_dec | input | 1 | Mode bit to load: 0 binary, 1 decimal |
| wr_rate | input | 7 | Rate value to load: [6:4] prescaler select, [3:0] multiplier minus one |
| clr_wr | input | 1 | Write strobe for the flag clear |
| clr_bit | input | 1 | Data bit of the flag clear; a one clears |
| irq_en | input | 1 | Interrupt enable |
| flag | output | 1 | Sticky tick flag |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL assertions check four things on every cycle. The counters stay within their terminal counts and are zero whenever the divider is off or has just been written. The flag can rise only after a tick and falls only through a clear write with a one. The interrupt is never raised without the enable. The exact period for each mode and code, the restart after a mid-period write, and the repetition of ticks can only be shown by the bench's scenarios, which time each flag event against a period computed from the rate value.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
   localparam int RATE_W = 7;
   localparam int SEL_W  = 3;
   localparam int MUL_W  = 4;
   localparam int DEC_MAX_PRESCALE = 200000;

   typedef struct packed {
      logic              dec;
      logic [RATE_W-1:0] rate;
   } ptd_cfg_t;

   function automatic int unsigned dec_prescale(input logic [SEL_W-1:0] sel);
      int unsigned v;
      case (sel)
         3'd0:    v = 1000;
         3'd1:    v = 2000;
         3'd2:    v = 5000;
         3'd3:    v = 10000;
         3'd4:    v = 20000;
         3'd5:    v = 50000;
         3'd6:    v = 100000;
         default: v = 200000;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/ptd_rate_decode.sv
module ptd_rate_decode #(
   parameter int PRE_W      = 18,
   parameter int BIN_EXP_LO = 10,
   parameter bit DEC_EN     = 1'b1
) (
   input  ptd_pkg::ptd_cfg_t           cfg,
   output logic [PRE_W-1:0]            pre_term,
   output logic [ptd_pkg::MUL_W-1:0]   mul_term,
   output logic                        off
);
   localparam int SEL_W = ptd_pkg::SEL_W;
   localparam int MUL_W = ptd_pkg::MUL_W;

   logic [SEL_W-1:0] sel;
   logic             use_dec;
   logic [PRE_W-1:0] bin_term;
   logic [PRE_W-1:0] dec_term;

   assign sel      = cfg.rate[MUL_W +: SEL_W];
   assign mul_term = cfg.rate[MUL_W-1:0];

   generate
      if (DEC_EN) begin : g_dec_mode
         assign use_dec  = cfg.dec;
         assign dec_term = PRE_W'(ptd_pkg::dec_prescale(sel) - 32'd1);
      end else begin : g_bin_only
         assign use_dec  = 1'b0;
         assign dec_term = '0;
      end
   endgenerate

   always_comb begin
      if (sel == '0) begin
         bin_term = '0;
      end else begin
         bin_term = (PRE_W'(1) << (BIN_EXP_LO - 1 + int'(sel))) - PRE_W'(1);
      end
   end

   assign pre_term = use_dec ? dec_term : bin_term;
   assign off      = !use_dec && (sel == '0);
endmodule

// File: rtl/ptd_prescale_cnt.sv
module ptd_prescale_cnt #(
   parameter int PRE_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             run,
   input  logic [PRE_W-1:0] term,
   output logic [PRE_W-1:0] cnt,
   output logic             wrap
);
   logic at_term;

   assign at_term = (cnt == term);
   assign wrap    = run && at_term;

   always_ff @(posedge clk) begin
      if (rst || restart || !run) begin
         cnt <= '0;
      end else if (at_term) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + PRE_W'(1);
      end
   end

   AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt <= term)); // R2
endmodule

// File: rtl/ptd_mult_cnt.sv
module ptd_mult_cnt #(
   parameter int MUL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             run,
   input  logic             step,
   input  logic [MUL_W-1:0] term,
   output logic [MUL_W-1:0] cnt,
   output logic             tick
);
   logic at_term;

   assign at_term = (cnt == term);
   assign tick    = run && step && at_term;

   always_ff @(posedge clk) begin
      if (rst || restart || !run) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= at_term ? '0 : cnt + MUL_W'(1);
      end
   end

   AST_MUL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt <= term)); // R2
   AST_MUL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (run && !step && !restart) |=> $stable(cnt)); // R3
endmodule

// File: rtl/periodic_tick_divider.sv
module periodic_tick_divider #(
   parameter int PRE_W      = 18,
   parameter int BIN_EXP_LO = 10,
   parameter bit DEC_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic       wr_dec,
   input  logic [6:0] wr_rate,
   input  logic       clr_wr,
   input  logic       clr_bit,
   input  logic       irq_en,
   output logic       flag,
   output logic       irq
);
   localparam int MUL_W   = ptd_pkg::MUL_W;
   localparam int BIN_TOP = BIN_EXP_LO + 6;

   generate
      if (PRE_W > 32 || PRE_W < BIN_TOP) begin : g_bad_pre_w
         $error("PRE_W must cover the largest binary prescale and fit 32 bits");
      end
      if (DEC_EN && ((64'd1 << PRE_W) <= 64'(ptd_pkg::DEC_MAX_PRESCALE))) begin : g_bad_dec_w
         $error("PRE_W too narrow for the decimal prescaler set");
      end
      if (BIN_EXP_LO < 1) begin : g_bad_exp
         $error("BIN_EXP_LO must be at least 1");
      end
   endgenerate

   ptd_pkg::ptd_cfg_t       cfg_q;
   logic [PRE_W-1:0]        pre_term;
   logic [MUL_W-1:0]        mul_term;
   logic                    off;
   logic                    run;
   logic [PRE_W-1:0]        pre_cnt;
   logic                    pre_wrap;
   logic [MUL_W-1:0]        mul_cnt;
   logic                    tick;
   logic                    clr_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q.dec  <= wr_dec;
         cfg_q.rate <= wr_rate;
      end
   end

   ptd_rate_decode #(
      .PRE_W(PRE_W), .BIN_EXP_LO(BIN_EXP_LO), .DEC_EN(DEC_EN)
   ) u_decode (
      .cfg(cfg_q), .pre_term(pre_term), .mul_term(mul_term), .off(off)
   );

   assign run = !off;

   ptd_prescale_cnt #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst(rst), .restart(wr_en), .run(run),
      .term(pre_term), .cnt(pre_cnt), .wrap(pre_wrap)
   );

   ptd_mult_cnt #(.MUL_W(MUL_W)) u_mul (
      .clk(clk), .rst(rst), .restart(wr_en), .run(run), .step(pre_wrap),
      .term(mul_term), .cnt(mul_cnt), .tick(tick)
   );

   assign clr_hit = clr_wr && clr_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag <= 1'b0;
      end else if (tick) begin
         flag <= 1'b1;
      end else if (clr_hit) begin
         flag <= 1'b0;
      end
   end

   assign irq = flag && irq_en;

   AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (pre_cnt == '0 && mul_cnt == '0)); // R5
   AST_OFF_HELD: assert property (@(posedge clk) disable iff (rst)
      off |-> (pre_cnt == '0 && mul_cnt == '0)); // R4
   AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
      (off && !flag) |=> !flag); // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr_hit) |=> flag); // R6
   AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      $rose(flag) |-> $past(pre_wrap)); // R8
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      !irq_en |-> !irq); // R7
endmodule

// File: tb/tb_periodic_tick_divider.sv
module tb_periodic_tick_divider;
   localparam int CLK_PERIOD = 10;
   localparam int unsigned WDOG_CYC = 190000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic       wr_dec = 1'b0;
   logic [6:0] wr_rate = '0;
   logic       clr_wr = 1'b0;
   logic       clr_bit = 1'b0;
   logic       irq_en = 1'b0;
   logic       flag;
   logic       irq;

   int unsigned cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   periodic_tick_divider dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dec(wr_dec), .wr_rate(wr_rate),
      .clr_wr(clr_wr), .clr_bit(clr_bit), .irq_en(irq_en),
      .flag(flag), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!done && cyc >= WDOG_CYC) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_CYC);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   function automatic int unsigned exp_period(input bit d, input logic [6:0] r);
      int unsigned pre;
      int unsigned u;
      u = r[6:4];
      if (!d) begin
         pre = (u == 0) ? 0 : (32'd1 << (9 + u));
      end else begin
         case (u)
            0: pre = 1000;   1: pre = 2000;   2: pre = 5000;    3: pre = 10000;
            4: pre = 20000;  5: pre = 50000;  6: pre = 100000;  default: pre = 200000;
         endcase
      end
      return pre * (int'(r[3:0]) + 1);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_write(input bit d, input logic [6:0] r, output int unsigned wcyc);
      @(negedge clk);
      wr_en = 1'b1; wr_dec = d; wr_rate = r;
      @(negedge clk);
      wcyc = cyc;
      wr_en = 1'b0;
   endtask

   task automatic do_clear(input bit b);
      @(negedge clk);
      clr_wr = 1'b1; clr_bit = b;
      @(negedge clk);
      clr_wr = 1'b0; clr_bit = 1'b0;
   endtask

   task automatic wait_flag(input int unsigned limit, output int unsigned at);
      int unsigned start;
      start = cyc;
      while (!flag && (cyc - start) < limit) @(negedge clk);
      at = cyc;
   endtask

   task automatic run_period(input bit d, input logic [6:0] r, input string tag);
      int unsigned w, at, p;
      p = exp_period(d, r);
      do_write(d, r, w);
      do_clear(1'b1);
      wait_flag(p + 50, at);
      chk(flag && (at - w) == p, tag, longint'(at - w), longint'(p));
   endtask

   initial begin
      int unsigned w, at, p;
      void'($urandom(32'h5EED1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state and off after reset
      chk(flag == 1'b0, "R1 flag after reset", flag, 0);
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
      repeat (3000) @(negedge clk);
      chk(flag == 1'b0, "R1 stays off", flag, 0);

      // R2: binary periods
      run_period(1'b0, 7'h10, "R2 bin u1 m0");
      run_period(1'b0, 7'h22, "R2 bin u2 m2");
      // R3: decimal periods, code 0 is not off
      run_period(1'b1, 7'h00, "R3 dec u0 m0");
      run_period(1'b1, 7'h13, "R3 dec u1 m3");
      run_period(1'b1, 7'h20, "R3 dec u2 m0");

      // R4: binary upper 000 is off for any multiplier
      do_write(1'b0, 7'h0F, w);
      do_clear(1'b1);
      repeat (4000) @(negedge clk);
      chk(flag == 1'b0, "R4 off m15", flag, 0);
      do_write(1'b0, 7'h05, w);
      repeat (3000) @(negedge clk);
      chk(flag == 1'b0, "R4 off m5", flag, 0);

      // R5: mid-period rewrite restarts the count
      do_write(1'b0, 7'h10, w);
      do_clear(1'b1);
      repeat (600) @(negedge clk);
      do_write(1'b0, 7'h10, w);
      wait_flag(1200, at);
      chk(flag && (at - w) == 1024, "R5 restart", longint'(at - w), 1024);

      // R7: enable gating
      irq_en = 1'b0;
      #1 chk(irq == 1'b0, "R7 irq masked", irq, 0);
      irq_en = 1'b1;
      #1 chk(irq == 1'b1, "R7 irq enabled", irq, 1);
      // R6: sticky, write of zero ignored
      do_clear(1'b0);
      chk(flag == 1'b1, "R6 clear with zero", flag, 1);
      repeat (100) @(negedge clk);
      chk(flag == 1'b1, "R6 sticky", flag, 1);
      do_clear(1'b1);
      chk(flag == 1'b0, "R6 clear with one", flag, 0);
      chk(irq == 1'b0, "R7 irq follows clear", irq, 0);
      irq_en = 1'b0;

      // R8: free-running repetition
      do_write(1'b0, 7'h10, w);
      do_clear(1'b1);
      wait_flag(1100, at);
      chk(flag && (at - w) == 1024, "R8 first tick", longint'(at - w), 1024);
      do_clear(1'b1);
      wait_flag(1100, at);
      chk(flag && (at - w) == 2048, "R8 second tick", longint'(at - w), 2048);

      // Random periods, R2 and R3
      for (int i = 0; i < 6; i++) begin
         bit d;
         logic [6:0] r;
         d = 1'($urandom_range(0, 1));
         r[3:0] = 4'($urandom_range(0, 3));
         r[6:4] = d ? 3'($urandom_range(0, 1)) : 3'($urandom_range(1, 2));
         p = exp_period(d, r);
         run_period(d, r, d ? "R3 random dec" : "R2 random bin");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule